// File: doc/BRIEF.md
# I2C Master Interrupt and Status Register Bank

This block collects the event pulses that an I2C master core produces (FIFO overflow and underflow, abort, bus start, stop and activity, general call and similar) and latches each pulse into its own raw status bit. A read/write mask selects which raw bits reach a masked status view and the single interrupt line. Software acknowledges an event by reading a dedicated clear register: one per latched source, plus one combined register that clears them all at once. The interrupt line is the registered OR of the masked status.

Two of the status bits are not latched. They follow the FIFO fill levels against two software thresholds, so they stay high as long as the condition holds and cannot be acknowledged. A transmit-abort cause word is captured together with the abort event and is zeroed whenever the abort source is cleared, by either path.

The core sees a simple register port (read strobe, write strobe, byte offset, data). Reads return data one clock after the strobe, and a clearing read takes effect on that same edge.

Top module: `i2c_irq_stat_top`

## Requirements
- R1: A one-cycle high on event input bit k (k in 0,1,3,5..11) sets raw status bit k, which stays set until it is cleared. Bit meanings: 0 RX underflow, 1 RX overflow, 3 TX overflow, 5 read request, 6 transmit abort, 7 RX done, 8 bus activity, 9 stop seen, 10 start or restart seen, 11 general call.
- R2: Offset 0x34 reads the 12-bit raw status, 0x30 is the read/write mask (1 enables a source, reset value 0), and 0x2C reads raw AND mask.
- R3: A read of offset 0x40 clears every latched raw bit (all except bits 2 and 4).
- R4: A read clears exactly one latched bit: 0x44 bit 0, 0x48 bit 1, 0x4C bit 3, 0x50 bit 5, 0x54 bit 6, 0x58 bit 7, 0x5C bit 8, 0x60 bit 9, 0x64 bit 10, 0x68 bit 11.
- R5: Raw bit 2 is high whenever the RX level input exceeds the RX threshold at offset 0x38 (a setting of N fires at N+1 entries).
- R6: Raw bit 4 is high whenever the TX level input is less than or equal to the TX threshold at offset 0x3C.
- R7: Clearing reads have no effect on raw bits 2 and 4.
- R8: On a transmit-abort event the abort cause input, limited to bits 0-5, 11 and 12, is ORed into the cause register read at offset 0x80 (bit 0 seven-bit address NACK, 1 first ten-bit address byte NACK, 2 second ten-bit byte NACK, 3 data NACK, 4 general call NACK, 5 general call followed by read, 11 master disabled, 12 arbitration lost).
- R9: Reading 0x54 or 0x40 zeroes the cause register.
- R10: When an event and a clearing read of the same source fall in the same cycle, the bit stays set, and for the abort source the cause register holds the new cause.
- R11: The interrupt output is a register loaded each cycle with the OR of raw AND mask; it is 0 after reset and follows a masked event one cycle after the raw bit sets.
- R12: Read data appears one cycle after the read strobe; clear registers and unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid the cycle after rd_en_i |
| evt_i | input | 12 | Event pulses from the core, by raw bit position |
| abort_src_i | input | 16 | Abort cause word, sampled with evt_i[6] |
| rx_lvl_i | input | 5 | Current RX FIFO fill level |
| tx_lvl_i | input | 5 | Current TX FIFO fill level |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default level width of five bits, so threshold and level values run the full span 0 to 31. That reaches the edges of both comparisons: an RX threshold of 31 that can never fire, a TX threshold of 31 that always fires, and level values just one below and one above each setting. Same-cycle event and clear collisions, cause accumulation across two aborts, and the one-cycle lag of the interrupt line are driven directly.

// File: rtl/i2c_isc_pkg.sv
package i2c_isc_pkg;

  localparam int NSRC = 12;

  // Raw status bit positions (software decodes these)
  localparam int IDX_RXUF   = 0;
  localparam int IDX_RXOF   = 1;
  localparam int IDX_RXLVL  = 2;
  localparam int IDX_TXOF   = 3;
  localparam int IDX_TXLVL  = 4;
  localparam int IDX_RDREQ  = 5;
  localparam int IDX_ABORT  = 6;
  localparam int IDX_RXDONE = 7;
  localparam int IDX_BUSY   = 8;
  localparam int IDX_STOP   = 9;
  localparam int IDX_START  = 10;
  localparam int IDX_GCALL  = 11;

  localparam logic [NSRC-1:0] LEVEL_SRC = NSRC'((1 << IDX_RXLVL) | (1 << IDX_TXLVL));
  localparam logic [NSRC-1:0] LATCH_SRC = ~LEVEL_SRC;

  // Register offsets
  localparam logic [7:0] OFS_MASKED  = 8'h2C;
  localparam logic [7:0] OFS_MASK    = 8'h30;
  localparam logic [7:0] OFS_RAW     = 8'h34;
  localparam logic [7:0] OFS_RXTHR   = 8'h38;
  localparam logic [7:0] OFS_TXTHR   = 8'h3C;
  localparam logic [7:0] OFS_CLR_ALL = 8'h40;
  localparam logic [7:0] OFS_CAUSE   = 8'h80;

  localparam int CAUSE_W = 16;
  localparam logic [CAUSE_W-1:0] CAUSE_KEEP = 16'h183F;

  function automatic logic [NSRC-1:0] one_src(input int idx);
    return NSRC'(1) << idx;
  endfunction

  // Which latched bits a read of this offset clears
  function automatic logic [NSRC-1:0] clr_decode(input logic [7:0] ofs);
    logic [NSRC-1:0] v;
    case (ofs)
      OFS_CLR_ALL: v = LATCH_SRC;
      8'h44:       v = one_src(IDX_RXUF);
      8'h48:       v = one_src(IDX_RXOF);
      8'h4C:       v = one_src(IDX_TXOF);
      8'h50:       v = one_src(IDX_RDREQ);
      8'h54:       v = one_src(IDX_ABORT);
      8'h58:       v = one_src(IDX_RXDONE);
      8'h5C:       v = one_src(IDX_BUSY);
      8'h60:       v = one_src(IDX_STOP);
      8'h64:       v = one_src(IDX_START);
      8'h68:       v = one_src(IDX_GCALL);
      default:     v = '0;
    endcase
    return v;
  endfunction

  // RX setting N fires at N+1 entries
  function automatic logic rx_reached(input logic [15:0] lvl, input logic [15:0] thr);
    return lvl > thr;
  endfunction

  function automatic logic tx_drained(input logic [15:0] lvl, input logic [15:0] thr);
    return lvl <= thr;
  endfunction

endpackage

// File: rtl/isc_evt_latch.sv
module isc_evt_latch #(
  parameter int              NSRC     = 12,
  parameter logic [NSRC-1:0] CLR_MASK = '1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] q_o
);

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    if (CLR_MASK[i]) begin : g_latched
      logic bit_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       bit_q <= 1'b0;
        else if (set_i[i]) bit_q <= 1'b1;   // event beats clear
        else if (clr_i[i]) bit_q <= 1'b0;
      end
      assign q_o[i] = bit_q;

      assert_evt_sets_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i[i] |=> q_o[i]);
      assert_clr_drops_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i[i] && !set_i[i]) |=> !q_o[i]);
      assert_evt_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i[i] && set_i[i]) |=> q_o[i]);
      assert_holds_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i[i] && !set_i[i]) |=> $stable(q_o[i]));
    end else begin : g_level
      logic unused_lvl_bit;
      assign unused_lvl_bit = set_i[i] ^ clr_i[i];
      assign q_o[i] = 1'b0;
    end
  end

endmodule

// File: rtl/isc_lvl_irq.sv
module isc_lvl_irq
  import i2c_isc_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic [LVL_W-1:0] rx_lvl_i,
  input  logic [LVL_W-1:0] tx_lvl_i,
  input  logic [LVL_W-1:0] rx_thr_i,
  input  logic [LVL_W-1:0] tx_thr_i,
  output logic             rx_hit_o,
  output logic             tx_hit_o
);

  assign rx_hit_o = rx_reached(16'(rx_lvl_i), 16'(rx_thr_i));
  assign tx_hit_o = tx_drained(16'(tx_lvl_i), 16'(tx_thr_i));

endmodule

// File: rtl/isc_abort_cause.sv
module isc_abort_cause #(
  parameter int               CW   = 16,
  parameter logic [CW-1:0]    KEEP = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          capture_i,
  input  logic [CW-1:0] src_i,
  input  logic          clr_i,
  output logic [CW-1:0] cause_o
);

  logic [CW-1:0] cause_q;
  logic [CW-1:0] base_w;
  logic [CW-1:0] new_w;

  assign base_w = clr_i ? '0 : cause_q;
  assign new_w  = capture_i ? (base_w | (src_i & KEEP)) : base_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= '0;
    else         cause_q <= new_w;
  end

  assign cause_o = cause_q;

  assert_cause_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !capture_i) |=> (cause_o == '0));
  assert_cause_capt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> ((cause_o & $past(src_i & KEEP)) == $past(src_i & KEEP)));
  assert_cause_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_o & ~KEEP) == '0);

endmodule

// File: rtl/i2c_irq_stat_top.sv
module i2c_irq_stat_top
  import i2c_isc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LVL_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NSRC-1:0]   evt_i,
  input  logic [CAUSE_W-1:0] abort_src_i,
  input  logic [LVL_W-1:0]  rx_lvl_i,
  input  logic [LVL_W-1:0]  tx_lvl_i,
  output logic              irq_o
);

  logic [7:0]       ofs_w;
  logic [NSRC-1:0]  mask_q;
  logic [LVL_W-1:0] rx_thr_q;
  logic [LVL_W-1:0] tx_thr_q;
  logic [NSRC-1:0]  clr_vec;
  logic [NSRC-1:0]  latched_w;
  logic [NSRC-1:0]  raw_w;
  logic [NSRC-1:0]  masked_w;
  logic             rx_hit_w;
  logic             tx_hit_w;
  logic [CAUSE_W-1:0] cause_w;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic             irq_q;
  logic             unused_wdata;

  assign ofs_w   = 8'(addr_i);
  assign clr_vec = rd_en_i ? clr_decode(ofs_w) : '0;

  isc_evt_latch #(.NSRC(NSRC), .CLR_MASK(LATCH_SRC)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt_i),
    .clr_i  (clr_vec),
    .q_o    (latched_w)
  );

  isc_lvl_irq #(.LVL_W(LVL_W)) u_lvl (
    .rx_lvl_i (rx_lvl_i),
    .tx_lvl_i (tx_lvl_i),
    .rx_thr_i (rx_thr_q),
    .tx_thr_i (tx_thr_q),
    .rx_hit_o (rx_hit_w),
    .tx_hit_o (tx_hit_w)
  );

  isc_abort_cause #(.CW(CAUSE_W), .KEEP(CAUSE_KEEP)) u_cause (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (evt_i[IDX_ABORT]),
    .src_i     (abort_src_i),
    .clr_i     (clr_vec[IDX_ABORT]),
    .cause_o   (cause_w)
  );

  always_comb begin
    raw_w            = latched_w;
    raw_w[IDX_RXLVL] = rx_hit_w;
    raw_w[IDX_TXLVL] = tx_hit_w;
  end
  assign masked_w = raw_w & mask_q;

  // Configuration registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q   <= '0;
      rx_thr_q <= '0;
      tx_thr_q <= '0;
    end else if (wr_en_i) begin
      case (ofs_w)
        OFS_MASK:  mask_q   <= wdata_i[NSRC-1:0];
        OFS_RXTHR: rx_thr_q <= wdata_i[LVL_W-1:0];
        OFS_TXTHR: tx_thr_q <= wdata_i[LVL_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (ofs_w)
      OFS_MASKED: rd_mux = DATA_W'(masked_w);
      OFS_MASK:   rd_mux = DATA_W'(mask_q);
      OFS_RAW:    rd_mux = DATA_W'(raw_w);
      OFS_RXTHR:  rd_mux = DATA_W'(rx_thr_q);
      OFS_TXTHR:  rd_mux = DATA_W'(tx_thr_q);
      OFS_CAUSE:  rd_mux = DATA_W'(cause_w);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (rd_en_i) rdata_q <= rd_mux;
      irq_q <= |masked_w;
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;
  assign unused_wdata = ^wdata_i;

  assert_irq_follows_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(raw_w & mask_q))));
  assert_lvl_no_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_vec & LEVEL_SRC) == '0);
  assert_masked_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && ofs_w == OFS_MASKED) |=> (rdata_o == DATA_W'($past(raw_w & mask_q))));
  assert_clr_reads_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && clr_decode(ofs_w) != '0) |=> (rdata_o == '0));

endmodule

// File: tb/tb_i2c_irq_stat_top.sv
module tb_i2c_irq_stat_top;

  localparam int LVL_W = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [11:0] evt = '0;
  logic [15:0] asrc = '0;
  logic [4:0]  rx_lvl = '0;
  logic [4:0]  tx_lvl = 5'd1;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  i2c_irq_stat_top #(.ADDR_W(8), .DATA_W(16), .LVL_W(LVL_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .rd_en_i(rd_en), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt),
    .abort_src_i(asrc), .rx_lvl_i(rx_lvl), .tx_lvl_i(tx_lvl), .irq_o(irq)
  );

  // {rx_thr, tx_thr, rx_lvl, tx_lvl, exp_rx_bit2, exp_tx_bit4}
  localparam logic [21:0] VEC [8] = '{
    {5'd0,  5'd0,  5'd0,  5'd0,  1'b0, 1'b1},
    {5'd0,  5'd0,  5'd1,  5'd1,  1'b1, 1'b0},
    {5'd3,  5'd3,  5'd3,  5'd3,  1'b0, 1'b1},
    {5'd3,  5'd3,  5'd4,  5'd4,  1'b1, 1'b0},
    {5'd31, 5'd31, 5'd31, 5'd31, 1'b0, 1'b1},
    {5'd30, 5'd0,  5'd31, 5'd31, 1'b1, 1'b0},
    {5'd15, 5'd15, 5'd2,  5'd2,  1'b0, 1'b1},
    {5'd7,  5'd16, 5'd16, 5'd17, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic pulse(input logic [11:0] e, input logic [15:0] s);
    @(negedge clk); evt = e; asrc = s;
    @(negedge clk); evt = '0; asrc = '0;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  localparam logic [11:0] ALL_LATCH = 12'hFEB;

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Reset state
    check("R11 irq after reset", 32'(irq), 32'd0);
    rd(8'h34, d); check("R2 raw after reset", 32'(d), 32'h000);
    rd(8'h30, d); check("R2 mask after reset", 32'(d), 32'h000);

    // Threshold vectors (R5, R6)
    for (int i = 0; i < 8; i++) begin
      wr(8'h38, 16'(VEC[i][21:17]));
      wr(8'h3C, 16'(VEC[i][16:12]));
      @(negedge clk); rx_lvl = VEC[i][11:7]; tx_lvl = VEC[i][6:2];
      rd(8'h34, d);
      check("R5 rx threshold bit", 32'(d[2]), 32'(VEC[i][1]));
      check("R6 tx threshold bit", 32'(d[4]), 32'(VEC[i][0]));
    end

    // Park levels so bits 2 and 4 are low
    wr(8'h38, 16'd0); wr(8'h3C, 16'd0);
    @(negedge clk); rx_lvl = 5'd0; tx_lvl = 5'd1;

    // R1: all latched sources set and hold
    pulse(12'hFFF, 16'h0);
    repeat (3) @(negedge clk);
    rd(8'h34, d); check("R1 all events latched", 32'(d), 32'(ALL_LATCH));

    // R4 and R12: per-source clears
    begin
      logic [7:0] ofs [10] = '{8'h44, 8'h48, 8'h4C, 8'h50, 8'h54, 8'h58, 8'h5C, 8'h60, 8'h64, 8'h68};
      int         bidx [10] = '{0, 1, 3, 5, 6, 7, 8, 9, 10, 11};
      logic [11:0] expv;
      expv = ALL_LATCH;
      for (int k = 0; k < 10; k++) begin
        rd(ofs[k], d);
        if (k == 0) check("R12 clear register reads zero", 32'(d), 32'd0);
        expv[bidx[k]] = 1'b0;
        rd(8'h34, d); check("R4 single clear", 32'(d), 32'(expv));
      end
    end

    // R3 combined clear
    pulse(12'hFFF, 16'h0);
    rd(8'h40, d);
    rd(8'h34, d); check("R3 combined clear", 32'(d), 32'h000);

    // R7 level bits ignore clears
    @(negedge clk); rx_lvl = 5'd5; tx_lvl = 5'd0;
    rd(8'h40, d); rd(8'h44, d);
    rd(8'h34, d); check("R7 level bits survive clears", 32'(d), 32'h014);
    @(negedge clk); rx_lvl = 5'd0; tx_lvl = 5'd1;

    // R2 masking, R11 irq timing
    wr(8'h30, 16'h0041);
    rd(8'h30, d); check("R2 mask readback", 32'(d), 32'h041);
    @(negedge clk); evt = 12'h201;
    @(negedge clk); evt = '0;
    check("R11 irq one cycle behind raw", 32'(irq), 32'd0);
    @(negedge clk);
    check("R11 irq asserted", 32'(irq), 32'd1);
    rd(8'h2C, d); check("R2 masked status", 32'(d), 32'h001);
    rd(8'h44, d);
    @(negedge clk);
    check("R11 irq drops after clear", 32'(irq), 32'd0);
    rd(8'h34, d); check("R2 unmasked bit still raw", 32'(d), 32'h200);
    rd(8'h40, d);

    // R8 abort cause capture and accumulation
    pulse(12'h040, 16'hFFFF);
    rd(8'h80, d); check("R8 cause keeps defined bits", 32'(d), 32'h183F);
    rd(8'h54, d);
    rd(8'h80, d); check("R9 cause zeroed by abort clear", 32'(d), 32'h0000);
    pulse(12'h040, 16'h0001);
    pulse(12'h040, 16'h0008);
    rd(8'h80, d); check("R8 cause accumulates", 32'(d), 32'h0009);
    rd(8'h40, d);
    rd(8'h80, d); check("R9 cause zeroed by combined clear", 32'(d), 32'h0000);

    // R10 event beats same-cycle clear
    @(negedge clk); evt = 12'h840; asrc = 16'h1000; rd_en = 1'b1; addr = 8'h40;
    @(negedge clk); evt = '0; asrc = '0; rd_en = 1'b0;
    rd(8'h34, d); check("R10 event wins over clear", 32'(d), 32'h840);
    rd(8'h80, d); check("R10 cause kept on collision", 32'(d), 32'h1000);

    // R12 unmapped offset
    rd(8'h00, d); check("R12 unmapped reads zero", 32'(d), 32'h0000);

    summary();
  end

endmodule